// File: doc/BRIEF.md
# Triggered ADC Conversion Sequencer

This block runs a single analog-to-digital converter through a table of numbered conversion slots. Every slot has three settings of its own: the input channel to route through the analog mux, the trigger line that starts it, and the length of its sample window. When a trigger pulse arrives, every slot bound to that line becomes pending. A periodic timer tick is a typical trigger source. The sequencer then takes the pending slots one at a time, lowest index first. For each slot it drives the mux select, raises a sample strobe for the slot's window and then a convert strobe for a fixed conversion time. When the conversion finishes it emits a one-cycle end-of-conversion pulse tagged with the slot number.

A typical use binds slots 0 to 12 to one timer. The end-of-conversion of slot 12 then tells downstream logic that the whole batch is done. A new trigger may arrive before downstream logic has dealt with the previous batch, or even while the sequencer is still busy. The sequencer always accepts it: the bound slots become pending again and are converted once more. A trigger for a slot that is already pending is merged with the earlier request.

The slot configuration is static input. It is assumed stable while `busy` is high.

Top module: `conv_seq_top`

## Requirements
- R1: Each slot selects one of 16 input channels through its own 4-bit field, `cfg_chan[4*i+3:4*i]`. Two slots may select the same channel. `mux_sel` equals the channel of the slot being served and stays constant for the whole sample phase.
- R2: Each slot has a 2-bit trigger-select field, `cfg_src[2*i+1:2*i]`. Code 0 means the slot is never started. Code k (1 to 3) binds the slot to `trig_in[k-1]`. A single one-cycle pulse on a trigger line makes every slot bound to it pending.
- R3: Each slot has a 6-bit window field, `cfg_win[6*i+5:6*i]`. `adc_sample` is high for exactly window+1 clocks. `adc_convert` is then high for exactly 13 clocks, starting on the clock right after the sample phase.
- R4: Pending slots are served one at a time, in ascending slot order. `adc_sample` and `adc_convert` are never high together.
- R5: `eoc` is a one-cycle pulse, and `eoc_slot` (4 bits) gives the index of the slot that just finished. The pulse appears in the clock right after the last convert clock. If another slot is pending, its sample phase starts in that same clock.
- R6: With the block idle, consider a trigger sampled at clock edge E. The first end-of-conversion is visible after edge E+window+15. Each further back-to-back slot ends window+14 clocks after the one before it.
- R7: A trigger that arrives while the sequencer is busy is accepted. Slots that were already served become pending again and are converted again.
- R8: A trigger for a slot that is already pending is absorbed: that slot is converted only once for both requests.
- R9: After reset, `busy`, `eoc`, `adc_sample` and `adc_convert` are low and no slot is pending. `busy` is high whenever a slot is pending or being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 3 | One-cycle trigger pulses, one per source line |
| cfg_chan | input | 64 | Per-slot channel number, 4 bits per slot |
| cfg_src | input | 32 | Per-slot trigger select, 2 bits per slot, 0 = off |
| cfg_win | input | 96 | Per-slot sample window, 6 bits per slot |
| mux_sel | output | 4 | Channel select to the analog mux |
| adc_sample | output | 1 | Sample phase strobe to the converter |
| adc_convert | output | 1 | Conversion phase strobe to the converter |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| eoc_slot | output | 4 | Slot index that goes with `eoc` |
| busy | output | 1 | A slot is pending or in service |

## Verification
A corrupted pending vector shows up as a missing, duplicated or out-of-order `eoc_slot`, within one slot period (window+14 clocks) of the moment the corruption occurs. A wrong phase counter shows up at once as a sample or convert run of the wrong length. It also moves every later end-of-conversion edge, so the bench timestamps each pulse and compares it with an arithmetic schedule. A wrong decoded trigger select shows up as a slot that converts when it should stay silent, or stays silent when it should convert. A full sweep of codes against trigger lines exposes it.

// File: rtl/conv_seq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes nothing beyond a single clock domain.
package conv_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2
    } phase_t;

endpackage

// File: rtl/cs_trig_decode.sv
// Trigger fan-out: decodes each slot's source-select code against the
// trigger lines and raises a per-slot request. Code 0 never matches; code k
// matches trig_in[k-1]. Codes above NUM_TRIG (if SRC_W allows) never match.
module cs_trig_decode #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_TRIG  = 3,
    parameter int SRC_W     = 2
) (
    input  logic [NUM_TRIG-1:0]        trig_in,
    input  logic [NUM_SLOTS*SRC_W-1:0] cfg_src,
    output logic [NUM_SLOTS-1:0]       hit
);
    localparam int EXT_N = 1 << SRC_W;

    logic [EXT_N-1:0] trig_ext;

    // Line table indexed directly by select code, entry 0 tied low.
    always_comb begin
        trig_ext = '0;
        trig_ext[NUM_TRIG:1] = trig_in;
    end

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
            // Per-slot match of its select code.
            assign hit[i] = trig_ext[cfg_src[i*SRC_W +: SRC_W]];
        end
    endgenerate
endmodule

// File: rtl/cs_pend_pick.sv
// Pending-slot register with lowest-index-first selection.
// New requests OR into the vector, so a repeated request for a pending slot
// merges. A slot taken into service is cleared in the same edge; a request
// arriving in that edge for the same slot re-arms it.
module cs_pend_pick #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] hit,
    input  logic                 take,
    output logic                 any_pend,
    output logic [SLOT_W-1:0]    pick_idx
);
    logic [NUM_SLOTS-1:0] pend_q;
    logic [NUM_SLOTS-1:0] clr_mask;

    // Lowest set bit wins.
    always_comb begin
        pick_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (pend_q[i]) pick_idx = SLOT_W'(i);
        end
    end

    assign any_pend = |pend_q;

    // One-hot clear for the slot granted this cycle.
    always_comb begin
        clr_mask = '0;
        if (take) clr_mask[pick_idx] = 1'b1;
    end

    // Pending state update.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | hit;
    end
endmodule

// File: rtl/cs_phase_ctl.sv
// Converter phase controller: idle / sample / convert. It loads a slot's
// channel and window on grant, holds adc_sample for window+1 clocks, then
// adc_convert for CONV_CLKS clocks, then pulses eoc one clock later. On the
// last convert clock it grants the next pending slot directly, so slots run
// back to back with no idle gap.
module cs_phase_ctl
    import conv_seq_pkg::*;
#(
    parameter int WIN_W     = 6,
    parameter int CHAN_W    = 4,
    parameter int SLOT_W    = 4,
    parameter int CONV_CLKS = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_pend,
    input  logic [SLOT_W-1:0] pick_idx,
    input  logic [WIN_W-1:0]  pick_win,
    input  logic [CHAN_W-1:0] pick_chan,
    output logic              take,
    output logic [CHAN_W-1:0] mux_sel,
    output logic              adc_sample,
    output logic              adc_convert,
    output logic              eoc,
    output logic [SLOT_W-1:0] eoc_slot,
    output logic              active
);
    localparam int CV_W  = $clog2(CONV_CLKS);
    localparam int CNT_W = (WIN_W > CV_W) ? WIN_W : CV_W;

    phase_t            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CHAN_W-1:0] chan_q;
    logic              last_conv;

    assign last_conv = (phase_q == PH_CONV) && (cnt_q == '0);
    // Grant from idle, or chained off the final convert clock.
    assign take      = any_pend && ((phase_q == PH_IDLE) || last_conv);

    // Phase, counter and loaded slot context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            slot_q  <= '0;
            chan_q  <= '0;
        end else if (take) begin
            phase_q <= PH_SAMPLE;
            cnt_q   <= CNT_W'(pick_win);
            slot_q  <= pick_idx;
            chan_q  <= pick_chan;
        end else begin
            case (phase_q)
                PH_SAMPLE: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_CONV;
                        cnt_q   <= CNT_W'(CONV_CLKS - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_CONV: begin
                    if (cnt_q == '0) phase_q <= PH_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // End-of-conversion pulse and its slot tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc      <= 1'b0;
            eoc_slot <= '0;
        end else begin
            eoc <= last_conv;
            if (last_conv) eoc_slot <= slot_q;
        end
    end

    assign mux_sel     = chan_q;
    assign adc_sample  = (phase_q == PH_SAMPLE);
    assign adc_convert = (phase_q == PH_CONV);
    assign active      = (phase_q != PH_IDLE);
endmodule

// File: rtl/conv_seq_top.sv
// Triggered conversion sequencer top. It fans trigger lines out to slots,
// keeps the pending set, and drives one converter through the pending slots
// in ascending order. Configuration inputs must be stable while busy.
module conv_seq_top #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_TRIG  = 3,
    parameter int CHAN_W    = 4,
    parameter int WIN_W     = 6,
    parameter int CONV_CLKS = 13,
    localparam int SRC_W    = $clog2(NUM_TRIG + 1),
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_TRIG-1:0]           trig_in,
    input  logic [NUM_SLOTS*CHAN_W-1:0]   cfg_chan,
    input  logic [NUM_SLOTS*SRC_W-1:0]    cfg_src,
    input  logic [NUM_SLOTS*WIN_W-1:0]    cfg_win,
    output logic [CHAN_W-1:0]             mux_sel,
    output logic                          adc_sample,
    output logic                          adc_convert,
    output logic                          eoc,
    output logic [SLOT_W-1:0]             eoc_slot,
    output logic                          busy
);
    logic [NUM_SLOTS-1:0] hit;
    logic                 take;
    logic                 any_pend;
    logic [SLOT_W-1:0]    pick_idx;
    logic [WIN_W-1:0]     pick_win;
    logic [CHAN_W-1:0]    pick_chan;
    logic                 active;

    cs_trig_decode #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_TRIG(NUM_TRIG), .SRC_W(SRC_W)
    ) u_decode (
        .trig_in(trig_in), .cfg_src(cfg_src), .hit(hit)
    );

    cs_pend_pick #(
        .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
    ) u_pend (
        .clk(clk), .rst_n(rst_n), .hit(hit), .take(take),
        .any_pend(any_pend), .pick_idx(pick_idx)
    );

    // Fetch the selected slot's window and channel fields.
    always_comb begin
        pick_win  = cfg_win[pick_idx*WIN_W +: WIN_W];
        pick_chan = cfg_chan[pick_idx*CHAN_W +: CHAN_W];
    end

    cs_phase_ctl #(
        .WIN_W(WIN_W), .CHAN_W(CHAN_W), .SLOT_W(SLOT_W), .CONV_CLKS(CONV_CLKS)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .any_pend(any_pend), .pick_idx(pick_idx),
        .pick_win(pick_win), .pick_chan(pick_chan), .take(take),
        .mux_sel(mux_sel), .adc_sample(adc_sample), .adc_convert(adc_convert),
        .eoc(eoc), .eoc_slot(eoc_slot), .active(active)
    );

    assign busy = any_pend | active;
endmodule

// File: rtl/conv_seq_chk.sv
// Protocol checker for conv_seq_top, attached by bind. It watches only the
// top-level ports and keeps one run-length counter of its own.
module conv_seq_chk #(
    parameter int CHAN_W    = 4,
    parameter int SLOT_W    = 4,
    parameter int CONV_CLKS = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CHAN_W-1:0] mux_sel,
    input logic              adc_sample,
    input logic              adc_convert,
    input logic              eoc,
    input logic [SLOT_W-1:0] eoc_slot,
    input logic              busy
);
    logic [7:0] cv_run_q;

    // Length of the current convert run.
    always_ff @(posedge clk) begin
        if (!rst_n)           cv_run_q <= '0;
        else if (adc_convert) cv_run_q <= cv_run_q + 1'b1;
        else                  cv_run_q <= '0;
    end

    // R4: the converter is never sampling and converting at once.
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_sample && adc_convert));

    // R1: mux select holds through the sample phase.
    a_r1_mux_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sample && $past(adc_sample)) |-> $stable(mux_sel));

    // R3: conversion follows directly on the end of sampling.
    a_r3_conv_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_sample) |-> adc_convert);

    // R5: end-of-conversion is a single-cycle pulse.
    a_r5_eoc_single: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc);

    // R3: each end-of-conversion closes a convert run of full length.
    a_r3_conv_len: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> (cv_run_q == 8'(CONV_CLKS)));

    // R9: an idle sequencer drives no converter strobes.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!adc_sample && !adc_convert));
endmodule

bind conv_seq_top conv_seq_chk #(
    .CHAN_W(CHAN_W), .SLOT_W(SLOT_W), .CONV_CLKS(CONV_CLKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .adc_sample(adc_sample),
    .adc_convert(adc_convert), .eoc(eoc), .eoc_slot(eoc_slot), .busy(busy)
);

// File: tb/test_conv_seq_top.sv
// Self-checking bench: window sweep, trigger-select sweep, full batch,
// retrigger/absorb and multi-source runs, checked against an arithmetic
// schedule of end-of-conversion events.
module test_conv_seq_top;
    localparam int NS = 16;
    localparam int NT = 3;
    localparam int CONV = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NT-1:0]     trig_in = '0;
    logic [NS*4-1:0]   cfg_chan = '0;
    logic [NS*2-1:0]   cfg_src = '0;
    logic [NS*6-1:0]   cfg_win = '0;
    logic [3:0]        mux_sel;
    logic              adc_sample, adc_convert, eoc, busy;
    logic [3:0]        eoc_slot;

    conv_seq_top i_conv_seq_top (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_chan(cfg_chan),
        .cfg_src(cfg_src), .cfg_win(cfg_win), .mux_sel(mux_sel),
        .adc_sample(adc_sample), .adc_convert(adc_convert), .eoc(eoc),
        .eoc_slot(eoc_slot), .busy(busy)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int wv[NS];
    int cv[NS];
    int exp_s[64];
    int exp_n;

    // Event log from the monitor.
    int ev_slot[256], ev_smp[256], ev_cv[256], ev_ch[256], ev_cyc[256];
    int ev_n = 0;
    int smp_len = 0, cv_len = 0, smp_ch = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: close a record on eoc, then accumulate this cycle's phases.
    always @(negedge clk) begin
        if (rst_n && eoc) begin
            if (ev_n < 256) begin
                ev_slot[ev_n] = int'(eoc_slot);
                ev_smp[ev_n]  = smp_len;
                ev_cv[ev_n]   = cv_len;
                ev_ch[ev_n]   = smp_ch;
                ev_cyc[ev_n]  = cyc;
            end
            ev_n = ev_n + 1;
            smp_len = 0;
            cv_len = 0;
        end
        if (rst_n && adc_sample) begin
            if (smp_len > 0 && smp_ch != int'(mux_sel)) smp_ch = -1;
            else smp_ch = int'(mux_sel);
            smp_len = smp_len + 1;
        end
        if (rst_n && adc_convert) cv_len = cv_len + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic set_slot(input int i, input int ch, input int src, input int w);
        cfg_chan[i*4 +: 4] = 4'(ch);
        cfg_src[i*2 +: 2]  = 2'(src);
        cfg_win[i*6 +: 6]  = 6'(w);
        cv[i] = ch;
        wv[i] = w;
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < NS; i++) set_slot(i, 0, 0, 0);
    endtask

    task automatic fire(input logic [NT-1:0] m, output int t);
        @(negedge clk);
        trig_in = m;
        t = cyc + 1;
        @(negedge clk);
        trig_in = '0;
    endtask

    task automatic wait_idle();
        int lim;
        lim = 0;
        while (busy && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        chk(lim < 5000, "R9 idle wait", lim, 0);
        repeat (3) @(negedge clk);
    endtask

    // Compare the logged events from 'base' with exp_s[] and the schedule.
    task automatic check_run(input string req, input int base, input int t0);
        int tprev;
        chk(ev_n - base == exp_n, {req, " event count"}, ev_n - base, exp_n);
        for (int k = 0; k < exp_n && base + k < ev_n; k++) begin
            int s;
            int texp;
            s = exp_s[k];
            texp = (k == 0) ? t0 + wv[s] + 15 : tprev + wv[s] + 14;
            chk(ev_slot[base+k] == s, "R4/R5 slot order", ev_slot[base+k], s);
            chk(ev_smp[base+k] == wv[s] + 1, "R3 sample length", ev_smp[base+k], wv[s] + 1);
            chk(ev_cv[base+k] == CONV, "R3 convert length", ev_cv[base+k], CONV);
            chk(ev_ch[base+k] == cv[s], "R1 mux channel", ev_ch[base+k], cv[s]);
            chk(ev_cyc[base+k] == texp, "R6 eoc timing", ev_cyc[base+k], texp);
            tprev = texp;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int t0;
        int base;
        clear_cfg();
        repeat (3) @(negedge clk);
        // R9: reset state.
        chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
        chk(eoc == 1'b0, "R9 reset eoc", int'(eoc), 0);
        chk(adc_sample == 1'b0, "R9 reset sample", int'(adc_sample), 0);
        chk(adc_convert == 1'b0, "R9 reset convert", int'(adc_convert), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R9 idle after reset", int'(busy), 0);

        // R3/R6: sweep every window value on one slot.
        for (int w = 0; w < 64; w++) begin
            clear_cfg();
            set_slot(3, w % 16, 1, w);
            base = ev_n;
            exp_n = 1;
            exp_s[0] = 3;
            fire(3'b001, t0);
            wait_idle();
            check_run("R3 window sweep", base, t0);
        end

        // R2: every select code against every trigger line.
        for (int code = 0; code < 4; code++) begin
            for (int ln = 0; ln < NT; ln++) begin
                clear_cfg();
                set_slot(5, 9, code, 2);
                base = ev_n;
                exp_n = (code == ln + 1) ? 1 : 0;
                exp_s[0] = 5;
                fire(3'(1 << ln), t0);
                wait_idle();
                check_run("R2 select decode", base, t0);
            end
        end

        // R1/R4: batch of slots 0..12 with duplicate channels; others on other lines.
        clear_cfg();
        for (int i = 0; i < 13; i++) set_slot(i, (i < 2) ? 0 : (i + 3) % 16, 1, (i * 7) % 64);
        set_slot(13, 6, 2, 4);
        set_slot(14, 6, 2, 0);
        set_slot(15, 2, 3, 1);
        base = ev_n;
        exp_n = 13;
        for (int k = 0; k < 13; k++) exp_s[k] = k;
        fire(3'b001, t0);
        chk(busy == 1'b1, "R9 busy after trigger", int'(busy), 1);
        wait_idle();
        check_run("R4 batch", base, t0);
        chk(ev_slot[ev_n-1] == 12, "R4 batch ends on slot 12", ev_slot[ev_n-1], 12);

        // R7/R8: retrigger while slot 0 is in service.
        base = ev_n;
        exp_n = 14;
        exp_s[0] = 0;
        exp_s[1] = 0;
        for (int k = 1; k < 13; k++) exp_s[k+1] = k;
        fire(3'b001, t0);
        repeat (3) @(negedge clk);
        begin
            int t1;
            fire(3'b001, t1);
        end
        wait_idle();
        check_run("R7/R8 retrigger", base, t0);

        // R2: two lines in the same cycle feed one ascending pass.
        base = ev_n;
        exp_n = 15;
        for (int k = 0; k < 15; k++) exp_s[k] = k;
        fire(3'b011, t0);
        wait_idle();
        check_run("R2 two sources", base, t0);

        // R9: reset in mid-batch clears pending work.
        fire(3'b001, t0);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9 reset clears pending", int'(busy), 0);
        chk(adc_sample == 1'b0, "R9 reset stops sample", int'(adc_sample), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule